// File: doc/BRIEF.md
# Fractional clock rate generator

The block turns a stream of source clock enables into a slower stream of one-cycle enable strobes. The average output rate is the source rate divided by `1 + M/256`, where `M` is a programmable 8-bit numerator. It never divides by an integer. It only withholds a fraction of the source strobes. Serial peripherals such as UART, I2C or SPI take the strobe as their functional clock enable.

All logic runs on one clock, `clk_i`. The three candidate sources arrive as enable strobes in that domain. A 2-bit selector picks one of them or none. Register-style write ports load the numerator, the selector and the denominator code. A 9-bit accumulator decides which source strobes to swallow.

The only denominator the block supports is 256, written as code 0xFF. Any other code leaves the denominator at 256 and sets a sticky flag.

Top module: `frg_rate_gen`

## Requirements
- R1: After reset, `frac_en_o` and `unsup_o` are 0, the numerator is 0, the selector is 0 (oscillator source), and the accumulator is 0.
- R2: The selector encodes 0 = `src_tick_i[0]` (oscillator), 1 = `src_tick_i[1]` (main clock), 2 = `src_tick_i[2]` (PLL) and 3 = no source. Strobes on the unselected inputs have no effect on the output or on the accumulator.
- R3: With a numerator of 0, every strobe on the selected source produces an output strobe.
- R4: An accepted source strobe in cycle n raises `frac_en_o` in cycle n+1 only. Each source strobe yields at most one output strobe.
- R5: For each output strobe the accumulator gains the numerator. A source strobe that arrives while the accumulator is 256 or more is swallowed, and 256 is subtracted. Starting from 0, any run of 256+M selected strobes gives exactly 256 output strobes.
- R6: While the selector is 3, `frac_en_o` stays 0 and the accumulator holds its value. Output resumes from that held value once a source is selected again.
- R7: A numerator write in cycle n is used from the first source strobe after cycle n. A strobe in cycle n itself still uses the old value, and the write creates no extra output strobe.
- R8: A denominator write with any code other than 0xFF sets `unsup_o`, which stays set. The denominator remains 256 in every case. A later write of 0xFF does not clear the flag.
- R9: Reset clears `unsup_o` and the accumulator, and returns the selector and the numerator to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for all logic |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_tick_i | input | 3 | Source enable strobes: [0] oscillator, [1] main clock, [2] PLL |
| sel_we_i | input | 1 | Write strobe for the selector |
| sel_i | input | 2 | New selector value |
| mult_we_i | input | 1 | Write strobe for the numerator |
| mult_i | input | 8 | New numerator value |
| div_we_i | input | 1 | Write strobe for the denominator code |
| div_i | input | 8 | Denominator code (only 0xFF is supported) |
| frac_en_o | output | 1 | One-cycle output enable strobe |
| unsup_o | output | 1 | Sticky flag for an unsupported denominator code |

## Verification
Two things can fall in the same cycle: a numerator write and the accumulator update caused by a source strobe. A selector write can also meet the strobe it would redirect. The bench drives random writes together with dense strobes so that these collisions happen many times. A behavioural model then compares every cycle: the update must use the old numerator and the old selector, and the written value applies only from the following strobe. Pulse counts over 256+M strobes confirm that no collision adds or drops an output strobe.

// File: rtl/frg_pkg.sv
package frg_pkg;
  localparam int SEL_W = 2;
  typedef enum logic [SEL_W-1:0] {
    SRC_OSC  = 2'd0,
    SRC_MAIN = 2'd1,
    SRC_PLL  = 2'd2,
    SRC_NONE = 2'd3
  } src_sel_e;
endpackage

// File: rtl/frg_cfg_regs.sv
module frg_cfg_regs
  import frg_pkg::*;
#(
  parameter int MULT_W = 8,
  parameter int DEN_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_we_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              mult_we_i,
  input  logic [MULT_W-1:0] mult_i,
  input  logic              div_we_i,
  input  logic [DEN_W-1:0]  div_i,
  output src_sel_e          sel_o,
  output logic [MULT_W-1:0] mult_o,
  output logic              unsup_o
);
  localparam logic [DEN_W-1:0] DivOk = {DEN_W{1'b1}};

  src_sel_e          sel_q;
  logic [MULT_W-1:0] mult_q;
  logic              unsup_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q   <= SRC_OSC;
      mult_q  <= '0;
      unsup_q <= 1'b0;
    end else begin
      if (sel_we_i)  sel_q  <= src_sel_e'(sel_i);
      if (mult_we_i) mult_q <= mult_i;
      // denominator fixed; bad codes only latch the flag
      if (div_we_i && (div_i != DivOk)) unsup_q <= 1'b1;
    end
  end

  assign sel_o   = sel_q;
  assign mult_o  = mult_q;
  assign unsup_o = unsup_q;
endmodule

// File: rtl/frg_src_mux.sv
module frg_src_mux
  import frg_pkg::*;
#(
  parameter int NUM_SRC = 3
) (
  input  logic [NUM_SRC-1:0] src_tick_i,
  input  src_sel_e           sel_i,
  output logic               tick_o
);
  logic [NUM_SRC-1:0] hit;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign hit[g] = src_tick_i[g] && (sel_i == src_sel_e'(g));
  end

  assign tick_o = |hit;
endmodule

// File: rtl/frg_accum.sv
module frg_accum #(
  parameter int MULT_W = 8,
  parameter int DEN_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [MULT_W-1:0] mult_i,
  output logic              en_o,
  output logic [DEN_W:0]    acc_o
);
  localparam int ACC_W = DEN_W + 1;

  logic [ACC_W-1:0] acc_q;
  logic             en_q;
  logic             full;

  assign full = acc_q[DEN_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      en_q  <= 1'b0;
    end else begin
      en_q <= tick_i && !full;
      if (tick_i) begin
        if (full) acc_q <= {1'b0, acc_q[DEN_W-1:0]};   // swallow, subtract 2^DEN_W
        else      acc_q <= acc_q + ACC_W'(mult_i);
      end
    end
  end

  assign en_o  = en_q;
  assign acc_o = acc_q;
endmodule

// File: rtl/frg_rate_gen.sv
module frg_rate_gen
  import frg_pkg::*;
#(
  parameter int MULT_W  = 8,
  parameter int DEN_W   = 8,
  parameter int NUM_SRC = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_tick_i,
  input  logic               sel_we_i,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic               mult_we_i,
  input  logic [MULT_W-1:0]  mult_i,
  input  logic               div_we_i,
  input  logic [DEN_W-1:0]   div_i,
  output logic               frac_en_o,
  output logic               unsup_o
);
  src_sel_e          sel_q;
  logic [MULT_W-1:0] mult_q;
  logic              sel_tick;
  logic [DEN_W:0]    acc_q;

  frg_cfg_regs #(.MULT_W(MULT_W), .DEN_W(DEN_W)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_we_i  (sel_we_i),
    .sel_i     (sel_i),
    .mult_we_i (mult_we_i),
    .mult_i    (mult_i),
    .div_we_i  (div_we_i),
    .div_i     (div_i),
    .sel_o     (sel_q),
    .mult_o    (mult_q),
    .unsup_o   (unsup_o)
  );

  frg_src_mux #(.NUM_SRC(NUM_SRC)) u_mux (
    .src_tick_i (src_tick_i),
    .sel_i      (sel_q),
    .tick_o     (sel_tick)
  );

  frg_accum #(.MULT_W(MULT_W), .DEN_W(DEN_W)) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (sel_tick),
    .mult_i (mult_q),
    .en_o   (frac_en_o),
    .acc_o  (acc_q)
  );
endmodule

// File: rtl/frg_rate_gen_chk.sv
module frg_rate_gen_chk #(
  parameter int MULT_W = 8,
  parameter int DEN_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              frac_en_o,
  input logic              unsup_o,
  input logic              sel_tick,
  input logic [DEN_W:0]    acc_q,
  input logic [MULT_W-1:0] mult_q,
  input logic [1:0]        sel_q
);
  a_r4_en_needs_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frac_en_o |-> $past(sel_tick));

  a_r5_swallow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_tick && acc_q[DEN_W]) |=> !frac_en_o);

  a_r5_subtract: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_tick && acc_q[DEN_W]) |=> (acc_q == $past(acc_q) - (DEN_W+1)'(1 << DEN_W)));

  a_r3_pass_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_tick && mult_q == '0 && !acc_q[DEN_W]) |=> frac_en_o);

  a_r6_none_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_q == 2'd3) |=> !frac_en_o);

  a_r6_none_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_q == 2'd3) |=> $stable(acc_q));

  a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unsup_o |=> unsup_o);
endmodule

bind frg_rate_gen frg_rate_gen_chk #(.MULT_W(MULT_W), .DEN_W(DEN_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .frac_en_o (frac_en_o),
  .unsup_o   (unsup_o),
  .sel_tick  (sel_tick),
  .acc_q     (acc_q),
  .mult_q    (mult_q),
  .sel_q     (sel_q)
);

// File: tb/frg_rate_gen_tb_top.sv
`timescale 1ns/1ps
module frg_rate_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] src = '0;
  logic       sel_we = 1'b0;
  logic [1:0] sel = '0;
  logic       mult_we = 1'b0;
  logic [7:0] mult = '0;
  logic       div_we = 1'b0;
  logic [7:0] div = '0;
  logic       en_o;
  logic       unsup_o;

  int    n_chk = 0;
  int    n_fail = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;  // 250 MHz

  frg_rate_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .src_tick_i(src),
    .sel_we_i(sel_we), .sel_i(sel),
    .mult_we_i(mult_we), .mult_i(mult),
    .div_we_i(div_we), .div_i(div),
    .frac_en_o(en_o), .unsup_o(unsup_o)
  );

  // behavioural reference
  int m_acc, m_mult, m_sel;
  bit m_flag, exp_en;
  always @(posedge clk) begin
    bit tk;
    if (!rst_n) begin
      m_acc = 0; m_mult = 0; m_sel = 0; m_flag = 0; exp_en = 0;
    end else begin
      tk = (m_sel < 3) && src[m_sel];
      exp_en = tk && (m_acc < 256);
      if (tk) m_acc = (m_acc >= 256) ? m_acc - 256 : m_acc + m_mult;
      if (mult_we) m_mult = mult;
      if (sel_we) m_sel = sel;
      if (div_we && div != 8'hFF) m_flag = 1;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk(cur_req, "frac_en_o", en_o, exp_en);
    chk((cur_req == "R9") ? "R9" : "R8", "unsup_o", unsup_o, m_flag);
  end

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    src = '0; sel_we = 0; mult_we = 0; div_we = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr_mult(int v);
    mult_we = 1; mult = 8'(v); @(negedge clk); mult_we = 0;
  endtask
  task automatic wr_sel(int v);
    sel_we = 1; sel = 2'(v); @(negedge clk); sel_we = 0;
  endtask
  task automatic wr_div(int v);
    div_we = 1; div = 8'(v); @(negedge clk); div_we = 0;
  endtask

  task automatic count_run(string req, int m);
    int cnt = 0;
    do_reset();
    cur_req = req;
    wr_mult(m);
    for (int i = 0; i < 256 + m; i++) begin
      src = 3'b001;
      @(negedge clk);
      cnt += en_o;
    end
    src = '0;
    chk(req, "pulses over 256+M strobes", cnt, 256);
  endtask

  task automatic rand_run(int cycles, bit wr_m, bit wr_s, int s_fixed);
    for (int i = 0; i < cycles; i++) begin
      src = 3'($urandom);
      mult_we = wr_m && ($urandom % 8 == 0);
      mult = 8'($urandom);
      sel_we = wr_s ? ($urandom % 6 == 0) : 1'b0;
      sel = wr_s ? 2'($urandom) : 2'(s_fixed);
      @(negedge clk);
    end
    mult_we = 0; sel_we = 0; src = '0;
  endtask

  initial begin
    void'($urandom(7));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "frac_en_o in reset", en_o, 0);
    chk("R1", "unsup_o in reset", unsup_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    src = 3'b001; @(negedge clk); src = '0;
    chk("R1", "osc source after reset", en_o, 1);
    @(negedge clk);
    chk("R4", "strobe one cycle wide", en_o, 0);

    // R3: zero numerator passes through, each source
    cur_req = "R3";
    for (int s = 0; s < 3; s++) begin
      wr_sel(s);
      rand_run(200, 0, 0, s);
    end

    // R2: only other sources strobe
    cur_req = "R2";
    wr_mult(77);
    wr_sel(1);
    for (int i = 0; i < 100; i++) begin src = 3'b101; @(negedge clk); end
    src = '0; @(negedge clk);
    chk("R2", "unselected sources ignored", en_o, 0);
    rand_run(300, 0, 0, 2);

    // R5: exact counts
    count_run("R5", 100);
    count_run("R5", 255);
    count_run("R5", 1);

    // R6: none source holds state
    do_reset();
    cur_req = "R6";
    wr_mult(180);
    for (int i = 0; i < 5; i++) begin src = 3'b001; @(negedge clk); end
    wr_sel(3);
    rand_run(150, 0, 0, 3);
    rand_run(200, 1, 0, 3);
    wr_sel(0);
    rand_run(200, 0, 0, 0);

    // R7: writes colliding with strobes
    cur_req = "R7";
    rand_run(3000, 1, 1, 0);
    sel_we = 1; sel = 2'd0; mult_we = 1; mult = 8'd0; src = 3'b111;
    @(negedge clk);
    sel_we = 0; mult_we = 0;
    rand_run(400, 0, 0, 0);

    // R8: denominator code handling
    do_reset();
    cur_req = "R8";
    wr_div(8'hFF);
    chk("R8", "0xFF leaves flag clear", unsup_o, 0);
    wr_div(8'h10);
    chk("R8", "bad code sets flag", unsup_o, 1);
    wr_div(8'hFF);
    chk("R8", "flag sticky", unsup_o, 1);
    begin
      int cnt = 0;
      wr_mult(60);
      for (int i = 0; i < 316; i++) begin src = 3'b001; @(negedge clk); cnt += en_o; end
      src = '0;
      chk("R8", "denominator stays 256", cnt, 256);
    end

    // R9: reset clears flag and config
    do_reset();
    cur_req = "R9";
    chk("R9", "flag cleared by reset", unsup_o, 0);
    rand_run(300, 0, 0, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule